// File: doc/BRIEF.md
# Dual Bridge Fault Supervisor with Automatic Retry

This block decides, on every clock, whether each of two power bridges may conduct. It takes comparator flags that have already been synchronized into the clock domain. There is one overcurrent flag per bridge, two temperature flags (one above the trip point and one above the release point), and two supply flags (one above the turn-on level and one above the turn-off level). From these it drives one enable gate per bridge. A low gate forces every switch of that bridge off.

Overcurrent is handled per bridge. Once a bridge's flag is seen, that bridge keeps running for a short programmable delay. It is then held off for a programmable disable time, after which it retries by itself. If the flag is still high when the disable time ends, the bridge is held off for another full window. Temperature and supply faults act on both bridges together. Each keeps its state between a set event and a clear event, which gives hysteresis. Four sticky status bits record which faults have occurred. They clear only on a clear pulse that arrives while the fault is gone.

Top module: `bridge_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both gates are low (supply lockout starts active) and all four status bits are 0.
- R2: Supply lockout is set in the cycle after `vs_above_off`=0 and cleared in the cycle after `vs_above_on`=1. With `vs_above_off`=1 and `vs_above_on`=0 it holds its state. The set condition wins over the clear condition.
- R3: Thermal shutdown is set in the cycle after `temp_above_trip`=1 and cleared in the cycle after `temp_above_rel`=0. With `temp_above_trip`=0 and `temp_above_rel`=1 it holds its state. The set condition wins over the clear condition.
- R4: When a bridge's overcurrent flag is sampled high on edge k while that bridge is in normal run, its gate stays high until edge k+`OC_DELAY_CYC` and is low from that edge on.
- R5: After going low for overcurrent, the gate stays low for exactly `DISABLE_CYC` cycles. It returns high if the overcurrent flag is low on the edge that ends the window.
- R6: If the overcurrent flag is high on the edge that ends the disable window, a new window of `DISABLE_CYC` cycles starts at once, with no new delay.
- R7: An overcurrent on one bridge never changes the gate of the other bridge.
- R8: Overcurrent flag activity during the delay or inside the disable window, other than on the edge that ends the window, neither extends nor restarts the sequence.
- R9: Status bits are `stat_oc_a`, `stat_oc_b`, `stat_therm` and `stat_uv`. Each bit goes to 1 in the cycle after its fault state is active; for overcurrent, active means the bridge is in delay or disable. A bit returns to 0 only after a `status_clr` pulse sampled while its fault state is inactive. Otherwise it holds.
- R10: A gate is high only when its bridge is in run or delay and neither global fault is active. The overcurrent timers keep running while a global fault holds the gates low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_a | input | 1 | Bridge A overcurrent flag |
| oc_b | input | 1 | Bridge B overcurrent flag |
| temp_above_trip | input | 1 | Die temperature above shutdown point |
| temp_above_rel | input | 1 | Die temperature above release point |
| vs_above_on | input | 1 | Supply above turn-on level |
| vs_above_off | input | 1 | Supply above turn-off level |
| status_clr | input | 1 | Clear pulse for the status bits |
| en_gate_a | output | 1 | Bridge A enable gate, high = may conduct |
| en_gate_b | output | 1 | Bridge B enable gate, high = may conduct |
| stat_oc_a | output | 1 | Sticky: bridge A overcurrent seen |
| stat_oc_b | output | 1 | Sticky: bridge B overcurrent seen |
| stat_therm | output | 1 | Sticky: thermal shutdown seen |
| stat_uv | output | 1 | Sticky: supply lockout seen |

## Verification
The bench targets the edge that ends a disable window with the overcurrent flag still high. A design that wrongly re-entered the delay would show the gate high for a few cycles there, and one that released would show it high at once. Short overcurrent pulses are placed inside the delay and the disable window. A design that restarted its timer on them would hold the gate low too long. The supply and temperature flags are walked through their hold region, where a design lacking hysteresis would release early. Status clears are issued both during and after an active fault, so a bit that clears while its fault persists is caught.

// File: rtl/bridge_guard_pkg.sv
// Shared types for the bridge fault supervisor.
package bridge_guard_pkg;
    // Phase of a per-bridge overcurrent timer.
    typedef enum logic [1:0] {
        OC_RUN  = 2'd0,
        OC_WAIT = 2'd1,
        OC_OFF  = 2'd2
    } oc_phase_t;
endpackage

// File: rtl/oc_retry_timer.sv
// Per-bridge overcurrent timer: delay, timed disable, then automatic retry.
// Assumes oc_flag is already synchronized. DLY_CYC and HOLD_CYC are both >= 1.
module oc_retry_timer
    import bridge_guard_pkg::*;
#(
    parameter int DLY_CYC  = 50,
    parameter int HOLD_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    output logic gate_ok,
    output logic fault_active
);
    localparam int MAXC = (DLY_CYC > HOLD_CYC) ? DLY_CYC : HOLD_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DLY_LD  = CW'(DLY_CYC - 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);

    oc_phase_t       phase;
    logic [CW-1:0]   cnt;

    // Phase and countdown sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= OC_RUN;
            cnt   <= '0;
        end else begin
            unique case (phase)
                OC_RUN: begin
                    if (oc_flag) begin
                        phase <= OC_WAIT;
                        cnt   <= DLY_LD;
                    end
                end
                OC_WAIT: begin
                    if (cnt == '0) begin
                        phase <= OC_OFF;
                        cnt   <= HOLD_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                OC_OFF: begin
                    if (cnt == '0) begin
                        if (oc_flag) cnt <= HOLD_LD;
                        else         phase <= OC_RUN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= OC_RUN;
            endcase
        end
    end

    // Bridge may conduct unless in the disable window.
    assign gate_ok      = (phase != OC_OFF);
    assign fault_active = (phase != OC_RUN);
endmodule

// File: rtl/hyst_latch.sv
// Set/clear state holder giving hysteresis between two comparator events.
// Assumes set_evt and clr_evt are synchronized; set wins when both are true.
module hyst_latch #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic q
);
    // Hold state between set and clear events.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= RST_VAL;
        else if (set_evt) q <= 1'b1;
        else if (clr_evt) q <= 1'b0;
    end
endmodule

// File: rtl/sticky_bank.sv
// Bank of sticky status bits: set while a fault is active, cleared by a pulse
// only when the fault is inactive. Assumes clr is a single-cycle pulse.
module sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] active,
    input  logic         clr,
    output logic [N-1:0] flags
);
    // Record each fault until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= active | (flags & {N{~clr}});
    end
endmodule

// File: rtl/bridge_guard.sv
// Dual bridge fault supervisor. Per-bridge overcurrent causes a delayed, timed
// disable with automatic retry. Thermal and supply faults gate both bridges with
// hysteresis. All inputs are assumed synchronized to clk.
module bridge_guard #(
    parameter int OC_DELAY_CYC = 50,
    parameter int DISABLE_CYC  = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_a,
    input  logic oc_b,
    input  logic temp_above_trip,
    input  logic temp_above_rel,
    input  logic vs_above_on,
    input  logic vs_above_off,
    input  logic status_clr,
    output logic en_gate_a,
    output logic en_gate_b,
    output logic stat_oc_a,
    output logic stat_oc_b,
    output logic stat_therm,
    output logic stat_uv
);
    localparam int NB = 2;

    logic [NB-1:0] oc_in;
    logic [NB-1:0] oc_gate_ok;
    logic [NB-1:0] oc_fault;
    logic          therm_fault;
    logic          uv_fault;
    logic [3:0]    stat_vec;

    assign oc_in = {oc_b, oc_a};

    // One independent retry timer per bridge.
    for (genvar b = 0; b < NB; b++) begin : g_br
        oc_retry_timer #(
            .DLY_CYC (OC_DELAY_CYC),
            .HOLD_CYC(DISABLE_CYC)
        ) u_tmr (
            .clk         (clk),
            .rst_n       (rst_n),
            .oc_flag     (oc_in[b]),
            .gate_ok     (oc_gate_ok[b]),
            .fault_active(oc_fault[b])
        );
    end

    // Thermal shutdown: set above trip, released below release point.
    hyst_latch #(.RST_VAL(1'b0)) u_therm (
        .clk(clk), .rst_n(rst_n),
        .set_evt(temp_above_trip), .clr_evt(~temp_above_rel),
        .q(therm_fault)
    );

    // Supply lockout: active from reset, cleared above turn-on level.
    hyst_latch #(.RST_VAL(1'b1)) u_uv (
        .clk(clk), .rst_n(rst_n),
        .set_evt(~vs_above_off), .clr_evt(vs_above_on),
        .q(uv_fault)
    );

    sticky_bank #(.N(4)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .active({uv_fault, therm_fault, oc_fault[1], oc_fault[0]}),
        .clr(status_clr),
        .flags(stat_vec)
    );

    assign en_gate_a  = oc_gate_ok[0] & ~therm_fault & ~uv_fault;
    assign en_gate_b  = oc_gate_ok[1] & ~therm_fault & ~uv_fault;
    assign stat_oc_a  = stat_vec[0];
    assign stat_oc_b  = stat_vec[1];
    assign stat_therm = stat_vec[2];
    assign stat_uv    = stat_vec[3];
endmodule

// File: rtl/bridge_guard_chk.sv
// Property checker for bridge_guard, attached by bind.
module bridge_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic vs_above_on,
    input logic vs_above_off,
    input logic temp_above_trip,
    input logic temp_above_rel,
    input logic status_clr,
    input logic en_gate_a,
    input logic en_gate_b,
    input logic stat_oc_a,
    input logic stat_therm,
    input logic stat_uv,
    input logic therm_fault,
    input logic uv_fault
);
    a_r2_uv_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_above_off |=> (!en_gate_a && !en_gate_b));
    a_r2_uv_hysteresis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_fault && !vs_above_on) |=> (!en_gate_a && !en_gate_b));
    a_r3_trip_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        temp_above_trip |=> (!en_gate_a && !en_gate_b));
    a_r3_therm_hysteresis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_fault && temp_above_rel) |=> (!en_gate_a && !en_gate_b));
    a_r9_therm_clear_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_therm) |-> $past(status_clr));
    a_r9_uv_clear_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_uv) |-> $past(status_clr));
    a_r9_oc_clear_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_oc_a) |-> $past(status_clr));
endmodule

bind bridge_guard bridge_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .vs_above_on(vs_above_on), .vs_above_off(vs_above_off),
    .temp_above_trip(temp_above_trip), .temp_above_rel(temp_above_rel),
    .status_clr(status_clr),
    .en_gate_a(en_gate_a), .en_gate_b(en_gate_b),
    .stat_oc_a(stat_oc_a), .stat_therm(stat_therm), .stat_uv(stat_uv),
    .therm_fault(therm_fault), .uv_fault(uv_fault)
);

// File: tb/sim_bridge_guard.sv
// Bench: behavioural reference model compared with the design on every clock.
module sim_bridge_guard;
    localparam int D = 3;
    localparam int T = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_a = 0, oc_b = 0, temp_above_trip = 0, temp_above_rel = 0;
    logic vs_above_on = 0, vs_above_off = 0, status_clr = 0;
    logic en_gate_a, en_gate_b, stat_oc_a, stat_oc_b, stat_therm, stat_uv;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    bridge_guard #(.OC_DELAY_CYC(D), .DISABLE_CYC(T)) u0 (.*);

    // Reference model state: per bridge time left in delay / off window.
    int  wait_left [2];
    int  off_left  [2];
    bit  m_uv, m_th;
    bit  m_st [4];

    function automatic bit m_gate(int b);
        return (off_left[b] == 0) && !m_uv && !m_th;
    endfunction

    // Advance the model on each edge using the inputs present at that edge.
    always @(posedge clk) begin
        bit ocv [2];
        bit act [4];
        ocv[0] = oc_a; ocv[1] = oc_b;
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin wait_left[b] = 0; off_left[b] = 0; end
            m_uv = 1; m_th = 0;
            for (int i = 0; i < 4; i++) m_st[i] = 0;
        end else begin
            act[0] = (wait_left[0] > 0) || (off_left[0] > 0);
            act[1] = (wait_left[1] > 0) || (off_left[1] > 0);
            act[2] = m_th; act[3] = m_uv;
            for (int i = 0; i < 4; i++) m_st[i] = act[i] || (m_st[i] && !status_clr);
            for (int b = 0; b < 2; b++) begin
                if (wait_left[b] > 0) begin
                    wait_left[b]--;
                    if (wait_left[b] == 0) off_left[b] = T;
                end else if (off_left[b] > 0) begin
                    off_left[b]--;
                    if (off_left[b] == 0 && ocv[b]) off_left[b] = T;
                end else if (ocv[b]) begin
                    wait_left[b] = D;
                end
            end
            if (!vs_above_off) m_uv = 1; else if (vs_above_on) m_uv = 0;
            if (temp_above_trip) m_th = 1; else if (!temp_above_rel) m_th = 0;
        end
    end

    task automatic chk(string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        chk("en_gate_a", en_gate_a, m_gate(0));
        chk("en_gate_b", en_gate_b, m_gate(1));
        chk("stat_oc_a", stat_oc_a, m_st[0]);
        chk("stat_oc_b", stat_oc_b, m_st[1]);
        chk("stat_therm", stat_therm, m_st[2]);
        chk("stat_uv", stat_uv, m_st[3]);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_pulse;
        @(negedge clk); status_clr = 1;
        @(negedge clk); status_clr = 0;
    endtask

    task automatic pulse_oc_a(int len);
        @(negedge clk); oc_a = 1;
        cyc(len); oc_a = 0;
    endtask

    initial begin
        cur_req = "R1";
        cyc(4);
        @(negedge clk); rst_n = 1;
        cyc(3);
        // R2: lockout holds in the hysteresis band, releases above turn-on.
        cur_req = "R2";
        vs_above_off = 1; cyc(5);
        vs_above_on = 1;  cyc(3);
        vs_above_on = 0;  cyc(4);
        vs_above_off = 0; cyc(3);
        vs_above_off = 1; cyc(3);
        vs_above_on = 1; vs_above_off = 0; cyc(2);
        vs_above_off = 1; cyc(3);
        // R9: clear status after the lockout has gone.
        cur_req = "R9";
        clr_pulse(); cyc(3);
        // R4 / R5: single overcurrent pulse on bridge A.
        cur_req = "R4_R5";
        pulse_oc_a(1); cyc(T + D + 4);
        // R8: pulses during delay and mid-window are ignored.
        cur_req = "R8";
        pulse_oc_a(1); cyc(1);
        pulse_oc_a(1); cyc(4);
        pulse_oc_a(2); cyc(T + 6);
        // R6: overcurrent still high when the window ends.
        cur_req = "R6";
        @(negedge clk); oc_a = 1; cyc(2 * T + D + 2); oc_a = 0;
        cyc(T + 3);
        // R7: bridge B overcurrent leaves bridge A running.
        cur_req = "R7";
        @(negedge clk); oc_b = 1; cyc(1); oc_b = 0;
        cyc(T + D + 4);
        // R9: clear while no fault, then clear while fault active.
        cur_req = "R9";
        clr_pulse(); cyc(2);
        @(negedge clk); oc_a = 1; cyc(1); oc_a = 0; cyc(D + 2);
        clr_pulse(); cyc(T + 3);
        clr_pulse(); cyc(2);
        // R3: thermal trip, hold in band, release below release point.
        cur_req = "R3";
        temp_above_rel = 1; cyc(2);
        temp_above_trip = 1; cyc(2);
        temp_above_trip = 0; cyc(5);
        temp_above_rel = 0; cyc(3);
        temp_above_rel = 1; temp_above_trip = 1; cyc(2);
        // R10: overcurrent timers run during a global fault.
        cur_req = "R10";
        temp_above_trip = 0;
        @(negedge clk); oc_b = 1; cyc(1); oc_b = 0; cyc(D + 3);
        temp_above_rel = 0; cyc(T + 4);
        clr_pulse(); cyc(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule